// File: doc/BRIEF.md
# Mode-Selectable 4-Bit Arithmetic/Logic Unit

This block is a purely combinational 4-bit arithmetic/logic slice. Two operands, a 4-bit function code and a mode bit choose one result. When the mode bit is low the code selects an arithmetic form, and the carry input takes part in it. When the mode bit is high the same code selects a bitwise logic function, and the carry input plays no part.

Besides the 4-bit result, the slice drives several status outputs:

- a carry out;
- an all-ones flag, which works as an equality compare when the slice subtracts;
- a group propagate and a group generate.

The propagate and generate outputs let several slices sit behind an external lookahead carry unit. The function codes that the table does not name fall back to a defined pass-through, so the outputs never go unknown.

Top module: `alu4_mode`

## Requirements
- R1: Code 0000: with mode 0, F = A + 1111 + CIN (that is A - 1 + CIN) and COUT is bit 4 of that 5-bit sum. With mode 1, F = NOT A.
- R2: Code 0110: with mode 0, F = A + (NOT B) + CIN (A - B - 1 + CIN) and COUT is bit 4 of that sum. With mode 1, F = NOT (A XOR B).
- R3: Code 1001: with mode 0, F = A + B + CIN and COUT is bit 4 of the sum. With mode 1, F = A XOR B.
- R4: Code 1011: with mode 0, F = (A OR B) + CIN and COUT is bit 4 of the sum. With mode 1, F = A OR B.
- R5: Code 1100: with mode 0, F = A + A + CIN and COUT is bit 4 of the sum. With mode 1, F = 0000.
- R6: Code 1111 and all ten other codes: with mode 0, F = A + CIN and COUT is bit 4 of the sum. With mode 1, F = A.
- R7: With mode 1, COUT, P and G are all 0, and CIN has no effect on F.
- R8: The equality output is 1 exactly when all four bits of F are 1. With code 0110, mode 0 and CIN 0, it is therefore 1 exactly when A equals B.
- R9: With mode 0, G is 1 when the sum of the two addend terms with CIN 0 exceeds 15. P is 1 when that sum equals exactly 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function code, bit 3 first |
| mode_i | input | 1 | 0 selects arithmetic, 1 selects logic |
| cin_i | input | 1 | Carry input, used in arithmetic mode only |
| f_o | output | 4 | Result |
| cout_o | output | 1 | Carry out of bit 3 |
| aeqb_o | output | 1 | High when F is 1111 |
| prop_o | output | 1 | Group propagate |
| gen_o | output | 1 | Group generate |

## Verification
The stimulus is an exhaustive sweep of every operand pair, every function code, both modes and both carry values, checked against a behavioural model of the table.

- Pairs with A equal to B, and pairs that differ in a single bit, separate a correct XNOR and subtract path from one that swaps or drops the inversion of B.
- The carry-in toggle under both modes shows whether CIN is used in arithmetic mode and ignored in logic mode.
- Sums that land exactly on 15 or above it separate propagate from generate.
- The ten unnamed codes confirm the pass-through fallback rather than some other operation.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    localparam int unsigned ALU_W = 4;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        FN_DEC    = 4'b0000,
        FN_SUBM1  = 4'b0110,
        FN_ADD    = 4'b1001,
        FN_ORADD  = 4'b1011,
        FN_DOUBLE = 4'b1100,
        FN_PASS   = 4'b1111
    } fn_code_e;

    typedef struct packed {
        logic [ALU_W-1:0] x;
        logic [ALU_W-1:0] y;
    } addend_t;
endpackage

// File: rtl/alu4_addend_sel.sv
module alu4_addend_sel
    import alu4_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     x_o,
    output logic [W-1:0]     y_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    addend_t add_d;

    always_comb begin
        add_d.x = a_i;
        add_d.y = '0;
        case (sel_i)
            FN_DEC:    add_d.y = ALL_ONES;
            FN_SUBM1:  add_d.y = ~b_i;
            FN_ADD:    add_d.y = b_i;
            FN_ORADD:  add_d.x = a_i | b_i;
            FN_DOUBLE: add_d.y = a_i;
            default:   add_d.y = '0;
        endcase
    end

    assign x_o = add_d.x;
    assign y_o = add_d.y;
endmodule

// File: rtl/alu4_adder.sv
module alu4_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         prop_o,
    output logic         gen_o
);
    logic [W:0]   carry;
    logic [W-1:0] pbit;
    logic [W-1:0] gbit;
    logic [W:0]   gacc;
    logic [W:0]   pacc;

    assign carry[0] = cin_i;
    assign gacc[0]  = 1'b0;
    assign pacc[0]  = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pbit[i]    = x_i[i] ^ y_i[i];
        assign gbit[i]    = x_i[i] & y_i[i];
        assign sum_o[i]   = pbit[i] ^ carry[i];
        assign carry[i+1] = gbit[i] | (pbit[i] & carry[i]);
        assign gacc[i+1]  = gbit[i] | (pbit[i] & gacc[i]);
        assign pacc[i+1]  = pacc[i] & pbit[i];
    end

    assign cout_o = carry[W];
    assign prop_o = pacc[W];
    assign gen_o  = gacc[W];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     f_o
);
    always_comb begin
        case (sel_i)
            FN_DEC:    f_o = ~a_i;
            FN_SUBM1:  f_o = ~(a_i ^ b_i);
            FN_ADD:    f_o = a_i ^ b_i;
            FN_ORADD:  f_o = a_i | b_i;
            FN_DOUBLE: f_o = '0;
            default:   f_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu4_mode.sv
module alu4_mode
    import alu4_pkg::*;
(
    input  logic [ALU_W-1:0] a_i,
    input  logic [ALU_W-1:0] b_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             mode_i,
    input  logic             cin_i,
    output logic [ALU_W-1:0] f_o,
    output logic             cout_o,
    output logic             aeqb_o,
    output logic             prop_o,
    output logic             gen_o
);
    logic [ALU_W-1:0] x_w;
    logic [ALU_W-1:0] y_w;
    logic [ALU_W-1:0] sum_w;
    logic             carry_w;
    logic             grp_p_w;
    logic             grp_g_w;
    logic [ALU_W-1:0] lres_w;

    alu4_addend_sel #(.W(ALU_W)) i_addend (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (sel_i),
        .x_o   (x_w),
        .y_o   (y_w)
    );

    alu4_adder #(.W(ALU_W)) i_adder (
        .x_i    (x_w),
        .y_i    (y_w),
        .cin_i  (cin_i),
        .sum_o  (sum_w),
        .cout_o (carry_w),
        .prop_o (grp_p_w),
        .gen_o  (grp_g_w)
    );

    alu4_logic #(.W(ALU_W)) i_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (sel_i),
        .f_o   (lres_w)
    );

    always_comb begin
        if (mode_i) begin
            f_o    = lres_w;
            cout_o = 1'b0;
            prop_o = 1'b0;
            gen_o  = 1'b0;
        end else begin
            f_o    = sum_w;
            cout_o = carry_w;
            prop_o = grp_p_w;
            gen_o  = grp_g_w;
        end
        aeqb_o = &f_o;
    end
endmodule

// File: rtl/alu4_mode_chk.sv
module alu4_mode_chk
    import alu4_pkg::*;
(
    input logic [ALU_W-1:0] a_i,
    input logic [ALU_W-1:0] b_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             mode_i,
    input logic             cin_i,
    input logic [ALU_W-1:0] f_o,
    input logic             cout_o,
    input logic             aeqb_o,
    input logic             prop_o,
    input logic             gen_o
);
    always_comb begin
        if (mode_i) begin
            AST_LOGIC_NO_CARRY: assert (!cout_o && !prop_o && !gen_o); // R7
        end
        if (mode_i && sel_i == 4'b1100) begin
            AST_LOGIC_ZERO: assert (f_o == '0); // R5
        end
        if (mode_i && sel_i == 4'b1111) begin
            AST_LOGIC_PASS: assert (f_o == a_i); // R6
        end
        if (!mode_i && sel_i == 4'b0110 && !cin_i) begin
            AST_EQ_COMPARE: assert (aeqb_o == (a_i == b_i)); // R8
        end
        if (!mode_i && gen_o) begin
            AST_GEN_CARRY: assert (cout_o); // R9
        end
        if (!mode_i && prop_o) begin
            AST_PROP_PASS: assert (cout_o == cin_i && f_o == (cin_i ? 4'b0000 : 4'b1111)); // R9
        end
        if (!mode_i && !prop_o && !gen_o) begin
            AST_NO_CARRY_OUT: assert (!cout_o); // R9
        end
        if (!mode_i && prop_o) begin
            AST_PG_EXCLUSIVE: assert (!gen_o); // R9
        end
    end
endmodule

bind alu4_mode alu4_mode_chk i_alu4_mode_chk (.*);

// File: tb/test_alu4_mode.sv
module test_alu4_mode;
    localparam int unsigned WATCHDOG = 100000;

    typedef struct {
        string      tag;
        logic [3:0] f;
        logic       cout;
        logic       aeqb;
        logic       p;
        logic       g;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a, b, sel;
    logic       mode, cin;
    logic [3:0] f;
    logic       cout, aeqb, prop, gen;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    alu4_mode i_alu4_mode (
        .a_i(a), .b_i(b), .sel_i(sel), .mode_i(mode), .cin_i(cin),
        .f_o(f), .cout_o(cout), .aeqb_o(aeqb), .prop_o(prop), .gen_o(gen)
    );

    function automatic exp_t model(input int av, input int bv, input int sv,
                                   input int mv, input int cv);
        exp_t e;
        int   x, y, s0, s;
        x = av; y = 0;
        case (sv)
            0:  begin e.tag = "R1"; y = 15; end
            6:  begin e.tag = "R2"; y = 15 - bv; end
            9:  begin e.tag = "R3"; y = bv; end
            11: begin e.tag = "R4"; x = av | bv; end
            12: begin e.tag = "R5"; y = av; end
            default: e.tag = "R6";
        endcase
        if (mv == 0) begin
            s0     = x + y;
            s      = s0 + cv;
            e.f    = 4'(s);
            e.cout = (s > 15);
            e.p    = (s0 == 15);
            e.g    = (s0 > 15);
        end else begin
            case (sv)
                0:  e.f = 4'(15 - av);
                6:  e.f = 4'(15 - (av ^ bv));
                9:  e.f = 4'(av ^ bv);
                11: e.f = 4'(av | bv);
                12: e.f = 4'd0;
                default: e.f = 4'(av);
            endcase
            e.cout = 1'b0; e.p = 1'b0; e.g = 1'b0;
        end
        e.aeqb = (e.f == 4'hF);
        return e;
    endfunction

    task automatic drive(input int av, input int bv, input int sv,
                         input int mv, input int cv);
        @(posedge clk);
        a = 4'(av); b = 4'(bv); sel = 4'(sv); mode = 1'(mv); cin = 1'(cv);
        sb_q.push_back(model(av, bv, sv, mv, cv));
    endtask

    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (f !== e.f || cout !== e.cout) begin
                n_fail++;
                $display("FAIL %s F/COUT a=%h b=%h s=%h m=%b c=%b: got %h/%b exp %h/%b",
                         e.tag, a, b, sel, mode, cin, f, cout, e.f, e.cout);
            end
            n_tests++;
            if (aeqb !== e.aeqb) begin
                n_fail++;
                $display("FAIL R8 aeqb a=%h b=%h s=%h m=%b c=%b: got %b exp %b",
                         a, b, sel, mode, cin, aeqb, e.aeqb);
            end
            n_tests++;
            if (prop !== e.p || gen !== e.g) begin
                n_fail++;
                $display("FAIL %s P/G a=%h b=%h s=%h m=%b c=%b: got %b%b exp %b%b",
                         (mode ? "R7" : "R9"), a, b, sel, mode, cin, prop, gen, e.p, e.g);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sel = '0; mode = 1'b0; cin = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // idle-state check with all inputs zero: R1, F = 0 + 1111 = 1111
        n_tests++;
        if (f !== 4'hF || cout !== 1'b0 || aeqb !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 idle: got f=%h c=%b e=%b exp f=f c=0 e=1", f, cout, aeqb);
        end
        rst_n = 1'b1;
        // R7: CIN ignored in logic mode, both CIN values swept below
        for (int s = 0; s < 16; s++)
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < 2; c++)
                    for (int ai = 0; ai < 16; ai++)
                        for (int bi = 0; bi < 16; bi++)
                            drive(ai, bi, s, m, c);
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule